// File: doc/BRIEF.md
# Ordering-Table Clear DMA Engine

This block is a fill-only DMA channel. It builds an empty ordering table in main memory: a list of words in which each entry points to the next-lower entry. Software writes a start byte address and an entry count, then writes the channel control word. The engine then emits one memory write per accepted cycle at descending word addresses. Each entry holds the 24-bit byte address of the word just below it. The final entry holds an end-of-list marker instead of a link.

When the last write has been accepted, a fixed completion delay runs. At its end the engine clears the busy bits of its control word and raises a one-cycle interrupt. Any control value other than the single start code is rejected: no memory is written, the busy bits are dropped from the stored value, and the interrupt fires at once. The engine never writes at an address below a configured memory floor. It never reads memory.

Top module: `otc_dma_engine`

## Requirements
- R1: After reset, `ctrl_o` is 0, `irq_o` is 0 and `mem_wr_valid` is 0.
- R2: A control write (`cfg_sel` = 2) whose value is not exactly 0x11000002 starts no memory write. It stores the written value with bits 24 and 28 cleared, and `irq_o` is high in the cycle after the write edge.
- R3: A run starts at the latched start address with its two low bits forced to zero.
- R4: A non-final entry written at address A holds (A − 4) masked to 24 bits in bits 23:0, with bits 31:24 zero. The next entry goes to A − 4.
- R5: With entry count N ≥ 1 (`cfg_sel` = 1, taken directly as a word count), exactly N entries are written. The one at the lowest address holds 0x00FFFFFF.
- R6: With entry count 0, exactly one entry is written: the terminator at the start address.
- R7: No write goes below MEM_BASE. An entry at an address no higher than MEM_BASE + 4 is written as the terminator, and the run ends there, even if count remains.
- R8: One entry is accepted per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high. While ready is low, valid, address and data hold steady.
- R9: `irq_o` is a one-cycle pulse that rises 16 cycles (DONE_DELAY) after the edge that accepts the final entry. From that same edge, `ctrl_o` has bits 24 and 28 cleared and its other bits kept.
- R10: While a run or its completion delay is in progress, register writes of every kind have no effect. A later start uses the address and count held before the run.
- R11: During a run, `ctrl_o` reads back the start code 0x11000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start address, 1 entry count, 2 control |
| cfg_wdata | input | 32 | Register write data |
| ctrl_o | output | 32 | Control word readback |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the request this cycle |
| mem_wr_addr | output | AW (24) | Byte address of the entry |
| mem_wr_data | output | 32 | Entry contents |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
A control write takes effect at the edge that samples it. A rejected code therefore shows its interrupt at the first falling edge after the write, and the bench checks it there. Writes are compared one by one at falling edges against a queue of expected entries. The bench records the cycle number of the final accepted write and requires the interrupt exactly 17 falling edges later: one for the accepting edge plus DONE_DELAY. It also requires the interrupt to be low at the next falling edge. Ready is driven 2 ns after each rising edge, so stall patterns never race the sampling.

// File: rtl/otc_pkg.sv
`timescale 1ns/1ps
package otc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_WAIT} otc_state_e;

  localparam logic [1:0]  SEL_ADDR   = 2'd0;
  localparam logic [1:0]  SEL_COUNT  = 2'd1;
  localparam logic [1:0]  SEL_CTRL   = 2'd2;

  localparam logic [31:0] START_CODE = 32'h1100_0002;
  localparam logic [31:0] BUSY_BITS  = 32'h1100_0000;
  localparam logic [31:0] END_MARK   = 32'h00FF_FFFF;
  localparam logic [31:0] LINK_MASK  = 32'h00FF_FFFF;
endpackage

// File: rtl/otc_addr_gen.sv
`timescale 1ns/1ps
// Walks the table downwards: current entry address, remaining count,
// final-entry detection and entry contents.
module otc_addr_gen #(
  parameter int AW       = 24,
  parameter int CW       = 16,
  parameter int MEM_BASE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] cur_addr,
  output logic          last,
  output logic [31:0]   entry
);
  import otc_pkg::*;

  localparam logic [AW-1:0] FLOOR_LIM = AW'(MEM_BASE + 4);

  logic [AW-1:0] cur_q;
  logic [CW-1:0] rem_q;
  logic [AW-1:0] link;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      cur_q <= {start_addr[AW-1:2], 2'b00};
      rem_q <= (count == '0) ? CW'(1) : count;
    end else if (step) begin
      cur_q <= cur_q - AW'(4);
      rem_q <= rem_q - CW'(1);
    end
  end

  assign link     = cur_q - AW'(4);
  assign last     = (rem_q <= CW'(1)) || (cur_q <= FLOOR_LIM);
  assign cur_addr = cur_q;
  assign entry    = last ? END_MARK : (32'(link) & LINK_MASK);

  // R4: each non-final step moves exactly one word down
  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cur_q == $past(cur_q) - AW'(4)));

  // R3: a freshly loaded address is word aligned
  p_load_align_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_q[1:0] == 2'b00));
endmodule

// File: rtl/otc_done_timer.sv
`timescale 1ns/1ps
// Counts the completion delay after the final entry is accepted.
module otc_done_timer #(
  parameter int DONE_DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expire
);
  localparam int TW = $clog2(DONE_DELAY + 1);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= TW'(DONE_DELAY - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expire = run_q && (cnt_q == '0);

  // R9: the delay is never restarted while it is counting
  p_no_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    arm |-> !run_q);
endmodule

// File: rtl/otc_dma_engine.sv
`timescale 1ns/1ps
module otc_dma_engine #(
  parameter int AW         = 24,
  parameter int CW         = 16,
  parameter int MEM_BASE   = 0,
  parameter int DONE_DELAY = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   ctrl_o,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic          irq_o
);
  import otc_pkg::*;

  otc_state_e    state_q;
  logic [31:0]   ctrl_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          irq_q;

  logic cfg_ok, is_ctrl, start, accept, last, expire, fin;

  assign cfg_ok  = cfg_we && (state_q == ST_IDLE);
  assign is_ctrl = cfg_ok && (cfg_sel == SEL_CTRL);
  assign start   = is_ctrl && (cfg_wdata == START_CODE);
  assign accept  = (state_q == ST_WALK) && mem_wr_ready;
  assign fin     = accept && last;

  otc_addr_gen #(.AW(AW), .CW(CW), .MEM_BASE(MEM_BASE)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .load       (start),
    .step       (accept && !last),
    .start_addr (addr_q),
    .count      (count_q),
    .cur_addr   (mem_wr_addr),
    .last       (last),
    .entry      (mem_wr_data)
  );

  otc_done_timer #(.DONE_DELAY(DONE_DELAY)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (fin),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      addr_q  <= '0;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cfg_ok) begin
          if (cfg_sel == SEL_ADDR)  addr_q  <= cfg_wdata[AW-1:0];
          if (cfg_sel == SEL_COUNT) count_q <= cfg_wdata[CW-1:0];
          if (start) begin
            ctrl_q  <= cfg_wdata;
            state_q <= ST_WALK;
          end else if (is_ctrl) begin
            ctrl_q  <= cfg_wdata & ~BUSY_BITS;
            irq_q   <= 1'b1;
          end
        end
        ST_WALK: if (fin) state_q <= ST_WAIT;
        ST_WAIT: if (expire) begin
          state_q <= ST_IDLE;
          ctrl_q  <= ctrl_q & ~BUSY_BITS;
          irq_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_wr_valid = (state_q == ST_WALK);
  assign ctrl_o       = ctrl_q;
  assign irq_o        = irq_q;

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((ctrl_o & BUSY_BITS) == '0) && !mem_wr_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_addr[1:0] == 2'b00));
  p_floor_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_addr >= AW'(MEM_BASE)));
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_data[31:24] == 8'h00));
  p_busy_readback_r11: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (ctrl_o == START_CODE));
endmodule

// File: tb/otc_dma_engine_tb_top.sv
`timescale 1ns/1ps
module otc_dma_engine_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   ctrl_o;
  logic          mem_wr_valid;
  logic          mem_wr_ready = 1'b1;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0]   mem_wr_data;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_acc = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [55:0] exp_q[$];

  always #4 clk = ~clk;

  otc_dma_engine dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_o(ctrl_o), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: mem_wr_ready = 1'b1;
      1: mem_wr_ready = lfsr[0];
      default: mem_wr_ready = 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every accepted write
  always @(negedge clk) begin
    if (!rst && mem_wr_valid && mem_wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R5 unexpected write", {8'h0, mem_wr_addr, mem_wr_data}, 64'h0);
      end else begin
        logic [55:0] e;
        e = exp_q.pop_front();
        check({mem_wr_addr, mem_wr_data} == e, "R4/R5 entry", {8'h0, mem_wr_addr, mem_wr_data}, {8'h0, e});
      end
      last_acc = cyc;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: push the table the requirements predict
  task automatic push_table(input logic [31:0] a, input int n);
    logic [AW-1:0] cur;
    int rem;
    cur = a[AW-1:0] & ~AW'(3);
    rem = (n == 0) ? 1 : n;
    forever begin
      bit fin;
      fin = (rem == 1) || (cur <= AW'(4));
      exp_q.push_back({cur, fin ? 32'h00FF_FFFF : (32'(cur - AW'(4)) & 32'h00FF_FFFF)});
      if (fin) break;
      cur = cur - AW'(4);
      rem--;
    end
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    @(negedge clk);
    while (!irq_o && t < 3000) begin @(negedge clk); t++; end
    check(irq_o == 1'b1, {req, " R9 irq seen"}, 64'(irq_o), 64'h1);
    check(cyc == last_acc + 17, {req, " R9 irq timing"}, 64'(cyc - last_acc), 64'd17);
    check(exp_q.size() == 0, {req, " R5 all entries"}, 64'(exp_q.size()), 64'h0);
    check(ctrl_o == 32'h0000_0002, {req, " R9 busy cleared"}, 64'(ctrl_o), 64'h2);
    @(negedge clk);
    check(irq_o == 1'b0, {req, " R9 pulse width"}, 64'(irq_o), 64'h0);
  endtask

  task automatic run_table(input logic [31:0] a, input int n, input string req);
    push_table(a, n);
    cfg_write(2'd0, a);
    cfg_write(2'd1, 32'(n));
    cfg_write(2'd2, 32'h1100_0002);
    wait_done(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ctrl_o == 0 && !irq_o && !mem_wr_valid, "R1 reset state",
          {ctrl_o, 30'h0, irq_o, mem_wr_valid}, 64'h0);

    ready_mode = 0; run_table(32'h0000_0100, 8, "R4 R5 R8 plain");
    ready_mode = 1; run_table(32'h0000_0203, 5, "R3 R8 stalls");
    ready_mode = 0; run_table(32'h0000_0400, 0, "R6 zero count");
    run_table(32'h0000_0010, 10, "R7 floor");
    run_table(32'h0000_0000, 3, "R7 at base");
    ready_mode = 1; run_table(32'h00FF_FFFC, 6, "R4 top of space");

    // R2: rejected control codes
    ready_mode = 0;
    cfg_write(2'd2, 32'h1100_0001);
    check(irq_o == 1'b1, "R2 irq on reject", 64'(irq_o), 64'h1);
    check(ctrl_o == 32'h0000_0001, "R2 stored value", 64'(ctrl_o), 64'h1);
    @(negedge clk);
    check(irq_o == 1'b0, "R2 irq pulse", 64'(irq_o), 64'h0);
    cfg_write(2'd2, 32'h0100_0002);
    check(ctrl_o == 32'h0000_0002, "R2 second reject value", 64'(ctrl_o), 64'h2);
    repeat (30) @(negedge clk);
    check(!mem_wr_valid && exp_q.size() == 0, "R2 no writes", 64'(mem_wr_valid), 64'h0);

    // R10 R11 R8: writes during a stalled run are ignored
    ready_mode = 2;
    push_table(32'h80, 4);
    cfg_write(2'd0, 32'h80);
    cfg_write(2'd1, 32'd4);
    cfg_write(2'd2, 32'h1100_0002);
    repeat (5) @(negedge clk);
    check(mem_wr_valid && mem_wr_addr == 24'h80, "R8 stall hold",
          {31'h0, mem_wr_valid, 8'h0, mem_wr_addr}, {32'h1, 32'h80});
    cfg_write(2'd0, 32'h500);
    cfg_write(2'd1, 32'd9);
    cfg_write(2'd2, 32'h0);
    check(ctrl_o == 32'h1100_0002, "R10 R11 busy readback", 64'(ctrl_o), 64'h1100_0002);
    check(!irq_o, "R10 no irq from busy write", 64'(irq_o), 64'h0);
    ready_mode = 0;
    wait_done("R10 stalled run");
    push_table(32'h80, 4);
    cfg_write(2'd2, 32'h1100_0002);
    wait_done("R10 regs kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule